// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit converts a logical address, made of a 16-bit segment selector and a 32-bit offset, into a linear address. The selector picks one entry of a descriptor table in memory. A selector flag chooses between two tables, global and local, and each table's start address sits in its own base register. The unit reads the 8-byte descriptor through a plain 32-bit read port as two words. It unpacks the segment base, limit, type and privilege fields, checks the offset against the limit, and returns the base plus the offset.

A requester raises `req_i` with the selector and offset. It keeps the request high until `ack_o` pulses, then lowers it. Only one translation runs at a time. When `ack_o` is high, exactly one of `valid_o` (a good translation) and `fault_o` (the offset is past the limit) is high. Software loads and reads back the two table base registers through a small write/read port.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `ack_o`, `valid_o`, `fault_o` and `mem_req_o` are low and both table base registers read back as zero.
- R2: When `cfg_we_i` is high at a clock edge, `cfg_wdata_i` is loaded into the global base register if `cfg_sel_i`=0 and into the local base register if `cfg_sel_i`=1. `cfg_rdata_o` always shows the register chosen by `cfg_sel_i`.
- R3: Selector bit 2 picks the table: 0 means global and 1 means local. Bits [15:3] are the entry index. The first read goes to base + index*8 and the second read goes to that address + 4, both modulo 2^32.
- R4: The low descriptor word is read first. Each read holds `mem_req_o` high, with a steady `mem_addr_o`, until a cycle in which `mem_rvalid_i` is high. In that cycle `mem_rdata_i` is taken as the word.
- R5: Descriptor fields, with lo as the first word and hi as the second:
  - segment base = {hi[31:24], hi[7:0], lo[31:16]}
  - limit = {hi[19:16], lo[15:0]}
  - type = hi[11:8]
  - privilege = hi[14:13]
  - `rpl_o` returns selector bits [1:0].
- R6: For a good translation, `lin_addr_o` equals segment base + offset modulo 2^32.
- R7: An offset greater than the zero-extended limit gives `fault_o` high and `valid_o` low during the acknowledge cycle. An offset equal to the limit is a good translation.
- R8: `ack_o` is a one-cycle pulse. It rises in the cycle after the edge that accepts the second read word. `valid_o` and `fault_o` are never high outside that cycle.
- R9: The selector, offset and table base values are captured when a request is accepted. Changing the selector or offset inputs, or writing a base register, while a translation is in flight does not change that translation's addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Base register write strobe |
| cfg_sel_i | input | 1 | Base register select: 0 global, 1 local |
| cfg_wdata_i | input | 32 | Base register write data |
| cfg_rdata_o | output | 32 | Readback of the selected base register |
| req_i | input | 1 | Translation request, held until ack |
| selector_i | input | 16 | Segment selector |
| offset_i | input | 32 | Offset within the segment |
| ack_o | output | 1 | Translation complete pulse |
| valid_o | output | 1 | Good translation, with ack |
| fault_o | output | 1 | Limit fault, with ack |
| lin_addr_o | output | 32 | Linear address |
| seg_limit_o | output | 20 | Descriptor limit |
| seg_type_o | output | 4 | Descriptor type field |
| seg_dpl_o | output | 2 | Descriptor privilege field |
| rpl_o | output | 2 | Requested privilege from the selector |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Descriptor word byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench drives offsets exactly at the limit and one above it. A design with an off-by-one comparison faults on the first case or passes the second. It uses descriptors whose base plus offset passes 2^32, and indexes 0 and 0x1FFF, where a wrong index shift or a misplaced split field gives the wrong addresses or a scrambled base. Memory latency varies from zero to several cycles, which exposes a design that drops its address or request early. The bench also changes the selector, the offset and a table base in the middle of a translation; a design that does not capture them at acceptance reads the second word from the wrong place or returns a mixed result.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned AW     = 32;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned IDX_W  = SEL_W - 3;
  localparam int unsigned LIM_W  = 20;
  localparam int unsigned TYP_W  = 4;
  localparam int unsigned PL_W   = 2;
  localparam int unsigned ENT_SH = 3;   // 8-byte entries
  localparam int unsigned N_TBL  = 2;

  typedef struct packed {
    logic [AW-1:0]    base;
    logic [LIM_W-1:0] limit;
    logic [TYP_W-1:0] kind;
    logic [PL_W-1:0]  dpl;
  } seg_desc_t;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_LO   = 2'd1,
    XS_HI   = 2'd2,
    XS_RESP = 2'd3
  } xl_state_e;
endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [AW-1:0] gbase_o,
  output logic [AW-1:0] lbase_o
);
  logic [AW-1:0] base_q [N_TBL];

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          base_q[t] <= '0;
      else if (we_i && (int'(sel_i) == t))  base_q[t] <= wdata_i;
    end
  end

  assign rdata_o = base_q[sel_i];
  assign gbase_o = base_q[0];
  assign lbase_o = base_q[1];
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             tbl_local_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    gbase_i,
  input  logic [AW-1:0]    lbase_i,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             accept_o,
  output logic             hi_done_o,
  output logic             resp_o,
  output logic             busy_o,
  output logic [31:0]      lo_word_o
);
  localparam int unsigned PAD_W = AW - IDX_W - ENT_SH;

  xl_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   lo_q;
  logic [AW-1:0] ent_addr;

  assign ent_addr = (tbl_local_i ? lbase_i : gbase_i)
                  + {{PAD_W{1'b0}}, idx_i, {ENT_SH{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (req_i) begin
          state_q <= XS_LO;
          addr_q  <= ent_addr;
        end
        XS_LO: if (mem_rvalid_i) begin
          state_q <= XS_HI;
          lo_q    <= mem_rdata_i;
          addr_q  <= addr_q + AW'(4);
        end
        XS_HI:   if (mem_rvalid_i) state_q <= XS_RESP;
        XS_RESP: state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == XS_LO) || (state_q == XS_HI);
  assign mem_addr_o = addr_q;
  assign accept_o   = (state_q == XS_IDLE) && req_i;
  assign hi_done_o  = (state_q == XS_HI) && mem_rvalid_i;
  assign resp_o     = (state_q == XS_RESP);
  assign busy_o     = (state_q != XS_IDLE);
  assign lo_word_o  = lo_q;
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_pkg::*;
(
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output seg_desc_t   desc_o
);
  logic unused_hi;

  always_comb begin
    desc_o.base  = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
    desc_o.limit = {hi_i[19:16], lo_i[15:0]};
    desc_o.kind  = hi_i[11:8];
    desc_o.dpl   = hi_i[14:13];
  end

  assign unused_hi = ^{hi_i[23:20], hi_i[15], hi_i[12]};
endmodule

// File: rtl/seg_limit_add.sv
module seg_limit_add
  import seg_pkg::*;
(
  input  seg_desc_t     desc_i,
  input  logic [AW-1:0] offset_i,
  output logic [AW-1:0] lin_o,
  output logic          over_o
);
  assign lin_o  = desc_i.base + offset_i;
  assign over_o = offset_i > {{(AW-LIM_W){1'b0}}, desc_i.limit};
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  output logic [AW-1:0]    cfg_rdata_o,
  input  logic             req_i,
  input  logic [SEL_W-1:0] selector_i,
  input  logic [AW-1:0]    offset_i,
  output logic             ack_o,
  output logic             valid_o,
  output logic             fault_o,
  output logic [AW-1:0]    lin_addr_o,
  output logic [LIM_W-1:0] seg_limit_o,
  output logic [TYP_W-1:0] seg_type_o,
  output logic [PL_W-1:0]  seg_dpl_o,
  output logic [PL_W-1:0]  rpl_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i
);
  logic [AW-1:0] gbase, lbase;
  logic          accept, hi_done, resp, busy;
  logic [31:0]   lo_word;
  seg_desc_t     desc;
  logic [AW-1:0] lin;
  logic          over;

  logic [AW-1:0]    off_q, lin_q;
  logic [PL_W-1:0]  rpl_q, dpl_q;
  logic [LIM_W-1:0] lim_q;
  logic [TYP_W-1:0] kind_q;
  logic             flt_q;

  seg_base_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .gbase_o (gbase),
    .lbase_o (lbase)
  );

  seg_desc_fetch u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .tbl_local_i  (selector_i[2]),
    .idx_i        (selector_i[SEL_W-1:3]),
    .gbase_i      (gbase),
    .lbase_i      (lbase),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .accept_o     (accept),
    .hi_done_o    (hi_done),
    .resp_o       (resp),
    .busy_o       (busy),
    .lo_word_o    (lo_word)
  );

  seg_desc_decode u_dec (
    .lo_i   (lo_word),
    .hi_i   (mem_rdata_i),
    .desc_o (desc)
  );

  seg_limit_add u_chk_add (
    .desc_i   (desc),
    .offset_i (off_q),
    .lin_o    (lin),
    .over_o   (over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      rpl_q <= '0;
    end else if (accept) begin
      off_q <= offset_i;
      rpl_q <= selector_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q  <= '0;
      lim_q  <= '0;
      kind_q <= '0;
      dpl_q  <= '0;
      flt_q  <= 1'b0;
    end else if (hi_done) begin
      lin_q  <= lin;
      lim_q  <= desc.limit;
      kind_q <= desc.kind;
      dpl_q  <= desc.dpl;
      flt_q  <= over;
    end
  end

  assign ack_o       = resp;
  assign valid_o     = resp && !flt_q;
  assign fault_o     = resp && flt_q;
  assign lin_addr_o  = lin_q;
  assign seg_limit_o = lim_q;
  assign seg_type_o  = kind_q;
  assign seg_dpl_o   = dpl_q;
  assign rpl_o       = rpl_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          ack_o,
  input logic          valid_o,
  input logic          fault_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i
);
  logic phase_q;   // 0: low word pending, 1: high word pending

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        phase_q <= 1'b0;
    else if (mem_req_o && mem_rvalid_i) phase_q <= !phase_q;
  end

  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r3_hi_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && !phase_q) |=>
      (mem_req_o && (mem_addr_o == $past(mem_addr_o) + AW'(4))));

  a_r8_ack_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && phase_q) |=> ack_o);

  a_r8_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r7_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($countones({valid_o, fault_o}) == 1));

  a_r8_result_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || fault_o) |-> ack_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_req_o);
endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy),
  .ack_o        (ack_o),
  .valid_o      (valid_o),
  .fault_o      (fault_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req = 1'b0;
  logic [15:0] sel_in = '0;
  logic [31:0] off_in = '0;
  logic        ack, valid, fault;
  logic [31:0] lin;
  logic [19:0] lim;
  logic [3:0]  kind;
  logic [1:0]  dpl, rpl;
  logic        mreq;
  logic [31:0] maddr;
  logic        mrvalid = 1'b0;
  logic [31:0] mrdata = '0;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] gsh = '0, lsh = '0, salt = 32'h5A5A_1234;
  logic        ovr_en = 1'b0;
  logic [31:0] ovr_addr = '0, ovr_lo = '0, ovr_hi = '0;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_i(req), .selector_i(sel_in), .offset_i(off_in),
    .ack_o(ack), .valid_o(valid), .fault_o(fault), .lin_addr_o(lin),
    .seg_limit_o(lim), .seg_type_o(kind), .seg_dpl_o(dpl), .rpl_o(rpl),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_rvalid_i(mrvalid), .mem_rdata_i(mrdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (ovr_en && a == ovr_addr)         return ovr_lo;
    if (ovr_en && a == ovr_addr + 32'd4) return ovr_hi;
    return (a * 32'h9E37_79B1) ^ (a >> 7) ^ salt;
  endfunction

  function automatic logic [31:0] mk_lo(logic [31:0] b, logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] mk_hi(logic [31:0] b, logic [19:0] l,
                                        logic [3:0] k, logic [1:0] d);
    return {b[31:24], 4'h0, l[19:16], 1'b0, d, 1'b0, k, b[23:16]};
  endfunction

  function automatic logic [31:0] ent_addr(logic [15:0] s);
    return (s[2] ? lsh : gsh) + {16'h0, s[15:3], 3'b000};
  endfunction

  task automatic cfg_write(logic s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s) lsh = d; else gsh = d;
  endtask

  task automatic read_back(logic s, logic [31:0] exp);
    cfg_sel = s;
    #1;
    chk("R2 base readback", cfg_rdata, exp);
  endtask

  task automatic serve(logic [31:0] a, bit poke);
    int lat = $urandom_range(0, 3);
    chk("R3/R4 mem_req", {31'h0, mreq}, 32'h1);
    chk("R3 read addr", maddr, a);
    sel_in = 16'($urandom);
    off_in = $urandom;
    if (poke) begin
      cfg_we = 1'b1; cfg_sel = 1'($urandom); cfg_wdata = $urandom;
      @(negedge clk);
      cfg_we = 1'b0;
      if (cfg_sel) lsh = cfg_wdata; else gsh = cfg_wdata;
      chk("R9 addr after base write", maddr, a);
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R4 addr hold", {mreq, maddr[30:0]}, {1'b1, a[30:0]});
    end
    mrvalid = 1'b1;
    mrdata  = mem_word(a);
    @(negedge clk);
    mrvalid = 1'b0;
    mrdata  = $urandom;
  endtask

  task automatic xlate(logic [15:0] s, logic [31:0] o, bit poke);
    logic [31:0] a, lo, hi, b, ex_lin;
    logic [19:0] l;
    bit          ex_flt;
    a  = ent_addr(s);
    lo = mem_word(a);
    hi = mem_word(a + 32'd4);
    b  = {hi[31:24], hi[7:0], lo[31:16]};
    l  = {hi[19:16], lo[15:0]};
    ex_lin = b + o;
    ex_flt = o > {12'h0, l};
    @(negedge clk);
    req = 1'b1; sel_in = s; off_in = o;
    @(negedge clk);
    serve(a, poke);
    serve(a + 32'd4, 1'b0);
    chk("R8 ack after hi word", {31'h0, ack}, 32'h1);
    chk("R7 fault flag", {31'h0, fault}, {31'h0, ex_flt});
    chk("R7 valid flag", {31'h0, valid}, {31'h0, !ex_flt});
    if (!ex_flt) chk("R6 linear address", lin, ex_lin);
    chk("R5 limit", {12'h0, lim}, {12'h0, l});
    chk("R5 type/dpl/rpl", {24'h0, kind, dpl, rpl}, {24'h0, hi[11:8], hi[14:13], s[1:0]});
    chk("R4 no read during ack", {31'h0, mreq}, 32'h0);
    req = 1'b0;
    @(negedge clk);
    chk("R8 ack one cycle", {29'h0, ack, valid, fault}, 32'h0);
  endtask

  task automatic set_desc(logic [15:0] s, logic [31:0] b, logic [19:0] l,
                          logic [3:0] k, logic [1:0] d);
    ovr_en = 1'b1; ovr_addr = ent_addr(s);
    ovr_lo = mk_lo(b, l); ovr_hi = mk_hi(b, l, k, d);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #23;
    chk("R1 ack/valid/fault/mem_req", {28'h0, ack, valid, fault, mreq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs idle", {28'h0, ack, valid, fault, mreq}, 32'h0);
    read_back(1'b0, 32'h0);
    read_back(1'b1, 32'h0);
    chk("R1 local reads zero", cfg_rdata, 32'h0);

    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'h0002_0400);
    read_back(1'b0, 32'h0001_0000);
    read_back(1'b1, 32'h0002_0400);

    // limit boundary, global table
    set_desc(16'h002B, 32'h1234_5600, 20'h00100, 4'hA, 2'd3);
    xlate(16'h002B, 32'h0000_0100, 1'b0);   // R7 equal -> valid
    xlate(16'h002B, 32'h0000_0101, 1'b0);   // R7 one past -> fault
    xlate(16'h002B, 32'h0000_0000, 1'b0);

    // wraparound, local table
    set_desc(16'h0016, 32'hFFFF_FF00, 20'hFFFFF, 4'h3, 2'd1);
    xlate(16'h0016, 32'h0000_0200, 1'b0);   // R6 wraps
    xlate(16'h0016, 32'h000F_FFFF, 1'b0);
    xlate(16'h0016, 32'h0010_0000, 1'b0);

    // extreme indices, R3
    ovr_en = 1'b0;
    xlate(16'hFFFB, 32'h0000_0010, 1'b0);
    xlate(16'hFFFF, 32'h0000_0010, 1'b0);
    xlate(16'h0000, 32'h0000_0010, 1'b0);
    xlate(16'h0004, 32'h0000_0010, 1'b0);

    // base write and input changes while busy, R9
    set_desc(16'h0038, 32'h0000_8000, 20'h00FFF, 4'h2, 2'd0);
    xlate(16'h0038, 32'h0000_0FFF, 1'b1);
    ovr_en = 1'b0;
    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'h0002_0400);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] s;
      logic [31:0] a, lo, hi, o;
      logic [19:0] l;
      s  = 16'($urandom);
      a  = ent_addr(s);
      lo = mem_word(a);
      hi = mem_word(a + 32'd4);
      l  = {hi[19:16], lo[15:0]};
      case ($urandom_range(0, 2))
        0:       o = $urandom_range(0, {12'h0, l});
        1:       o = {12'h0, l} + 32'd1 + $urandom_range(0, 255);
        default: o = $urandom;
      endcase
      xlate(s, o, ($urandom_range(0, 7) == 0));
      if (n % 50 == 49) begin
        salt = $urandom;
        cfg_write(1'($urandom), $urandom);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule